// File: doc/BRIEF.md
# Column-First DRAM Refresh and Start-Up Sequencer

This block keeps an asynchronous DRAM's contents alive by issuing refresh cycles in which the column strobes fall before the row strobe. In that ordering the memory picks the row from its own internal counter, so the block drives no address, no write enable and no output enable. It owns the two strobe lines only while a refresh is in progress. The rest of the time it leaves them idle (high) for the access controller.

After reset the block waits a programmable power-up pause. It then runs a fixed burst of refresh cycles on its own, and only after the last of these has finished precharging does it raise `init_done_o`. From that point a free-running interval timer adds one owed refresh per period to a small saturating tally. While anything is owed and the sequencer is idle, it holds `ref_req_o` high. The access controller answers with `ref_gnt_i` once the memory bus is free. Each accepted grant costs one owed refresh and starts one strobe sequence. All timing is given in clock cycles through parameters, so the cycle counts follow from the clock frequency and the memory's speed grade.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, the row strobe and both column strobes are high (inactive), `ref_req_o` is low and `init_done_o` is low.
- R2: For the first `PAUSE_CYC - 1` clock edges after reset release, all strobes stay high and no request is raised. The column strobes fall exactly `PAUSE_CYC` edges after release.
- R3: After the pause, `INIT_REFS` refresh sequences run back to back with no grant. `init_done_o` rises exactly `PAUSE_CYC + INIT_REFS*(CSR_CYC+RAS_CYC+RP_CYC)` edges after release and stays high afterwards. `ref_req_o` is never high while `init_done_o` is low.
- R4: Every refresh sequence starts with all column strobes low and the row strobe high for `CSR_CYC` cycles. The row strobe falls only while the column strobes are low, and all column strobe bits always carry the same value.
- R5: The row strobe stays low for exactly `RAS_CYC` cycles. The column strobes stay low for the first `CHR_CYC` of those cycles and are then high for the rest of the row-low time.
- R6: After the row strobe rises, every strobe stays high for at least `RP_CYC` cycles before any strobe falls again.
- R7: After `init_done_o` rises, one refresh becomes owed every `INTERVAL_CYC` cycles. With no grant, `ref_req_o` first rises exactly `INTERVAL_CYC` edges after the edge that raised `init_done_o`.
- R8: The owed tally saturates at `MAX_OWED`: after grants are withheld over more intervals than that, exactly `MAX_OWED` sequences can be granted before `ref_req_o` falls. With fewer intervals missed, the number of sequences equals the number of intervals missed.
- R9: `ref_gnt_i` has no effect while `ref_req_o` is low. After initialisation no strobe moves unless a grant was accepted on the previous edge.
- R10: A grant is accepted on an edge where `ref_req_o` and `ref_gnt_i` are both high. `ref_req_o` is low on the following cycle, and the refresh sequence begins in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_gnt_i | input | 1 | Access controller hands the strobes to the block |
| ref_req_o | output | 1 | At least one refresh is owed and the block is idle |
| row_stb_n_o | output | 1 | Row strobe, active low |
| col_stb_n_o | output | COL_STB | Column strobes (byte lanes), active low, moved together |
| init_done_o | output | 1 | Power-up pause and start-up refresh burst finished |

## Verification
The hardest condition to reach from the ports is a saturated owed tally. It requires the access controller to refuse service across several full refresh intervals, and the tally itself is not visible. The bench shortens the interval through parameters and keeps the grant low for four ticks against a limit of three. It then grants one sequence at a time and counts how many run before the request drops. A second, shorter starvation of two intervals confirms that the count matches the missed intervals when the tally is below the limit.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_CSR   = 3'd2,
    ST_RAS   = 3'd3,
    ST_PRE   = 3'd4
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int MAX_OWED = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic owed_nz_o
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] owed_q;

  assign owed_nz_o = (owed_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (owed_q != OW'(MAX_OWED)) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int INIT_REFS = 8,
  parameter int CSR_CYC   = 1,
  parameter int RAS_CYC   = 4,
  parameter int CHR_CYC   = 2,
  parameter int RP_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic init_done_o,
  output logic row_n_o,
  output logic col_n_o
);
  localparam int SPAN = max2(max2(PAUSE_CYC, RAS_CYC), max2(CSR_CYC, RP_CYC));
  localparam int CW   = $clog2(SPAN + 1);
  localparam int RW   = $clog2(INIT_REFS + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] refs_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cnt_q   <= '0;
      refs_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_PAUSE: if (cnt_q == CW'(PAUSE_CYC - 1)) begin
          state_q <= ST_CSR;
          cnt_q   <= '0;
        end
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= ST_CSR;
        end
        ST_CSR: if (cnt_q == CW'(CSR_CYC - 1)) begin
          state_q <= ST_RAS;
          cnt_q   <= '0;
        end
        ST_RAS: if (cnt_q == CW'(RAS_CYC - 1)) begin
          state_q <= ST_PRE;
          cnt_q   <= '0;
        end
        ST_PRE: if (cnt_q == CW'(RP_CYC - 1)) begin
          cnt_q <= '0;
          if (done_q) begin
            state_q <= ST_IDLE;
          end else if (refs_q == RW'(INIT_REFS - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            refs_q  <= refs_q + 1'b1;
            state_q <= ST_CSR;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign init_done_o = done_q;
  assign row_n_o     = (state_q != ST_RAS);
  // column strobes lead the row strobe, then release after the hold window
  assign col_n_o     = !((state_q == ST_CSR) ||
                         ((state_q == ST_RAS) && (cnt_q < CW'(CHR_CYC))));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_OWED     = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 4,
  parameter int CHR_CYC      = 2,
  parameter int RP_CYC       = 4,
  parameter int COL_STB      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_gnt_i,
  output logic               ref_req_o,
  output logic               row_stb_n_o,
  output logic [COL_STB-1:0] col_stb_n_o,
  output logic               init_done_o
);
  logic tick, owed_nz, idle, accept, col_n;

  assign ref_req_o = idle && init_done_o && owed_nz;
  assign accept    = ref_req_o && ref_gnt_i;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .tick_o (tick)
  );

  refresh_debt_counter #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tick),
    .dec_i     (accept),
    .owed_nz_o (owed_nz)
  );

  refresh_strobe_fsm #(
    .PAUSE_CYC (PAUSE_CYC),
    .INIT_REFS (INIT_REFS),
    .CSR_CYC   (CSR_CYC),
    .RAS_CYC   (RAS_CYC),
    .CHR_CYC   (CHR_CYC),
    .RP_CYC    (RP_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .idle_o      (idle),
    .init_done_o (init_done_o),
    .row_n_o     (row_stb_n_o),
    .col_n_o     (col_n)
  );

  for (genvar g = 0; g < COL_STB; g++) begin : g_col
    assign col_stb_n_o[g] = col_n;
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_CYC = 4,
  parameter int RP_CYC  = 4,
  parameter int COL_STB = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ref_gnt_i,
  input logic               ref_req_o,
  input logic               row_stb_n_o,
  input logic [COL_STB-1:0] col_stb_n_o,
  input logic               init_done_o
);
  localparam int HW = $clog2(RP_CYC + 1);
  localparam int LW = $clog2(RAS_CYC + 2);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= HW'(RP_CYC);
      lo_cnt <= '0;
    end else begin
      if (!row_stb_n_o)                 hi_cnt <= '0;
      else if (hi_cnt != HW'(RP_CYC))   hi_cnt <= hi_cnt + 1'b1;
      if (row_stb_n_o)                  lo_cnt <= '0;
      else if (lo_cnt != LW'(RAS_CYC + 1)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_col_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_n_o == '0) || (col_stb_n_o == '1));

  assert_cas_before_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_stb_n_o) |-> (col_stb_n_o == '0) && ($past(col_stb_n_o) == '0));

  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_stb_n_o) |-> (lo_cnt == LW'(RAS_CYC)));

  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(col_stb_n_o[0]) |-> (hi_cnt == HW'(RP_CYC)));

  assert_no_req_in_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !ref_req_o);

  assert_done_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_refresh_needs_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(col_stb_n_o[0]) && init_done_o) |-> $past(ref_req_o && ref_gnt_i));

  assert_req_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i) |=> !ref_req_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC (RAS_CYC),
  .RP_CYC  (RP_CYC),
  .COL_STB (COL_STB)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_gnt_i   (ref_gnt_i),
  .ref_req_o   (ref_req_o),
  .row_stb_n_o (row_stb_n_o),
  .col_stb_n_o (col_stb_n_o),
  .init_done_o (init_done_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20;
  localparam int NREF  = 8;
  localparam int IVL   = 150;
  localparam int OWE   = 3;
  localparam int CSR   = 2;
  localparam int RAS   = 5;
  localparam int CHR   = 3;
  localparam int RP    = 3;
  localparam int SEQ   = CSR + RAS + RP;
  localparam int DONE_AT = PAUSE + NREF * SEQ;

  // expected {row_n, col_n} per cycle of one refresh sequence
  localparam logic [1:0] SEQ_TBL [SEQ] = '{
    2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b11, 2'b11, 2'b11};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, row_n, done;
  logic [1:0] col_n;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_REFS(NREF), .INTERVAL_CYC(IVL), .MAX_OWED(OWE),
    .CSR_CYC(CSR), .RAS_CYC(RAS), .CHR_CYC(CHR), .RP_CYC(RP), .COL_STB(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt), .ref_req_o(req),
    .row_stb_n_o(row_n), .col_stb_n_o(col_n), .init_done_o(done)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int pat();
    return int'({row_n, col_n[0]});
  endfunction

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic walk_seq(input string rq, input int start);
    for (int j = 0; j < SEQ; j++) begin
      wait_until(start + j);
      check(!req && pat() == int'(SEQ_TBL[j]) && col_n[1] == col_n[0],
            rq, int'({req, col_n[1], row_n, col_n[0]}), int'(SEQ_TBL[j]));
    end
  endtask

  task automatic serve_all(output int served);
    served = 0;
    while (req && served < 10) begin
      gnt = 1'b1;
      @(negedge clk);
      gnt = 1'b0;
      served++;
      repeat (SEQ) @(negedge clk);
    end
  endtask

  initial begin
    int bad;
    int served;
    repeat (3) @(negedge clk);
    check(row_n && col_n == 2'b11 && !req && !done, "R1 reset state",
          int'({req, done, row_n, col_n}), 3);
    rst_n = 1'b1;

    bad = 0;
    for (int t = 1; t < PAUSE; t++) begin
      wait_until(t);
      if (pat() != 3 || req || done) bad++;
    end
    check(bad == 0, "R2 quiet during pause", bad, 0);
    wait_until(PAUSE);
    check(pat() == 2, "R2 first column strobe fall", pat(), 2);

    for (int s = 0; s < NREF; s++)
      walk_seq("R3 R4 R5 R6 start-up refresh", PAUSE + s * SEQ);
    wait_until(DONE_AT - 1);
    check(!done, "R3 init_done before last precharge ends", done, 0);
    wait_until(DONE_AT);
    check(done && pat() == 3 && !req, "R3 init_done after burst", int'({req, done}), 1);

    // stray grant with no request pending
    wait_until(DONE_AT + 40);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    bad = 0;
    for (int t = DONE_AT + 41; t < DONE_AT + IVL; t++) begin
      wait_until(t);
      if (pat() != 3 || req) bad++;
    end
    check(bad == 0, "R9 grant ignored and R7 no early request", bad, 0);
    wait_until(DONE_AT + IVL);
    check(req, "R7 request after one interval", req, 1);

    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    check(!req && col_n == 2'b00, "R10 request drops on accept", int'({req, col_n}), 0);
    walk_seq("R4 R5 R6 granted refresh", DONE_AT + IVL + 1);
    wait_until(DONE_AT + IVL + 1 + SEQ);
    check(!req && pat() == 3, "R8 single owed consumed", int'({req, row_n, col_n[0]}), 3);

    wait_until(DONE_AT + 5 * IVL + 10);
    serve_all(served);
    check(served == OWE, "R8 tally saturates", served, OWE);

    wait_until(DONE_AT + 7 * IVL + 10);
    serve_all(served);
    check(served == 2, "R8 tally below limit", served, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule